// File: doc/BRIEF.md
# Sparse-Input STDP Weight Updater

This block applies unsupervised spike-timing-dependent plasticity to the synapses of up to two winner neurons once a timestep has been decided. A pulse on `start` captures the winner list and the binary input vector. The block then walks every input position of each valid winner in turn. For each position it reads the 8-bit weight, raises it when the input was active and lowers it when the input was silent, and writes the result back. The result is clamped to a configured floor and ceiling.

The inputs are very sparse: about 150 of 784 are active per image. At that density depression falls on roughly four times as many synapses as potentiation. The default step sizes therefore make potentiation far larger than depression (15 up, 2 down), so the net change of a winner's weights stays positive (15×150 = 2250 against 2×634 = 1268). A 32-bit configuration register holds both step sizes and both limits.

The weight memory sits outside the block. It is reached through a byte-wide port with a separate read address and write address, and read data returns one cycle after the read. Reads are issued back to back, one per cycle. A write is forwarded when the same address is read in the very cycle it is written. `done` pulses once the whole list has been processed.

Top module: `stdp_updater`

## Requirements
- R1: After reset `done`, `mem_re` and `mem_we` are low, and the configuration holds step up 15, step down 2, floor 0 and ceiling 255.
- R2: Only the rows of winners whose valid flag is 1 are written. Every other neuron's weights are left unchanged.
- R3: A weight whose input bit is 1 becomes weight + step up, clamped to at most the ceiling.
- R4: A weight whose input bit is 0 becomes weight − step down, clamped to at least the floor.
- R5: `cfg_we` loads `cfg_wdata` into the configuration with step up in bits [7:0], step down in [15:8], floor in [23:16] and ceiling in [31:24].
- R6: Weight address = neuron × N_IN + input index. Reads are issued one per cycle in ascending index, slot 0 before slot 1. Each write goes to the address read one cycle earlier.
- R7: `done` is a one-cycle pulse. It comes one cycle after the last write, or one cycle after a start in which neither winner is valid.
- R8: When one neuron is listed in both slots, its weights receive two successive updates. The second update uses the value written by the first, even when that write coincides with the re-read.
- R9: A `start` pulse while an update is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| start | input | 1 | Begin an update pass |
| win0_id | input | NW | Neuron index of winner slot 0 |
| win0_vld | input | 1 | Slot 0 valid |
| win1_id | input | NW | Neuron index of winner slot 1 |
| win1_vld | input | 1 | Slot 1 valid |
| in_vec | input | N_IN | Binary input activity, bit i for input i |
| mem_re | output | 1 | Weight read strobe |
| mem_raddr | output | AW | Weight read address |
| mem_rdata | input | 8 | Weight read data, one cycle after the read |
| mem_we | output | 1 | Weight write strobe |
| mem_waddr | output | AW | Weight write address |
| mem_wdata | output | 8 | Updated weight |
| done | output | 1 | Pass complete pulse |

## Verification
Two functions can fall in the same cycle: the write-back of one weight and a fresh read of that same address. The memory model returns the old value when it reads and writes in the same cycle. A one-input instance is therefore given the same neuron in both winner slots, which makes the second pass re-read its only weight exactly while the first pass writes it. The result is judged on the final weight, which must show two stacked updates for both an active and a silent input. A stale read would leave only one update.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  // Packed so that ceiling sits in [31:24] and step up in [7:0]
  typedef struct packed {
    logic [7:0] ceil;
    logic [7:0] floor;
    logic [7:0] dn;
    logic [7:0] up;
  } stdp_cfg_t;

  localparam stdp_cfg_t CFG_RESET = '{ceil: 8'd255, floor: 8'd0, dn: 8'd2, up: 8'd15};
endpackage

// File: rtl/stdp_cfg_reg.sv
module stdp_cfg_reg
  import stdp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [31:0] wdata,
  output stdp_cfg_t cfg
);
  stdp_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (we) cfg_d = stdp_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= CFG_RESET;
    else        cfg <= cfg_d;
  end
endmodule

// File: rtl/stdp_weight_alu.sv
module stdp_weight_alu
  import stdp_pkg::*;
(
  input  logic [7:0] w_in,
  input  logic       active,
  input  stdp_cfg_t  cfg,
  output logic [7:0] w_out
);
  logic signed [9:0] raw;

  always_comb begin
    if (active) raw = $signed({2'b00, w_in}) + $signed({2'b00, cfg.up});
    else        raw = $signed({2'b00, w_in}) - $signed({2'b00, cfg.dn});
    if (raw < $signed({2'b00, cfg.floor}))     w_out = cfg.floor;
    else if (raw > $signed({2'b00, cfg.ceil})) w_out = cfg.ceil;
    else                                       w_out = raw[7:0];
  end
endmodule

// File: rtl/stdp_walk.sv
module stdp_walk #(
  parameter int N_IN  = 784,
  parameter int N_NEU = 200,
  parameter int AW    = 18,
  parameter int IW    = 10,
  parameter int NW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] id0,
  input  logic          vld0,
  input  logic [NW-1:0] id1,
  input  logic          vld1,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] raddr,
  output logic          last,
  output logic          empty_go
);
  localparam logic [IW-1:0] IDX_END = IW'(N_IN - 1);

  logic          busy_d, slot_q, slot_d, v1_q, v1_d;
  logic [IW-1:0] idx_d;
  logic [NW-1:0] id0_q, id0_d, id1_q, id1_d;
  logic [NW-1:0] cur_id;
  logic          accept;

  assign accept   = start && !busy;
  assign empty_go = accept && !vld0 && !vld1;
  assign cur_id   = slot_q ? id1_q : id0_q;
  assign raddr    = AW'(cur_id) * AW'(N_IN) + AW'(idx);
  assign last     = busy && (idx == IDX_END) && (slot_q || !v1_q);

  always_comb begin
    busy_d = busy; slot_d = slot_q; idx_d = idx;
    id0_d = id0_q; id1_d = id1_q; v1_d = v1_q;
    if (accept) begin
      id0_d  = id0; id1_d = id1; v1_d = vld1;
      busy_d = vld0 || vld1;
      slot_d = !vld0;
      idx_d  = '0;
    end else if (busy) begin
      if (idx == IDX_END) begin
        idx_d = '0;
        if (!slot_q && v1_q) slot_d = 1'b1;
        else                 busy_d = 1'b0;
      end else begin
        idx_d = idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; slot_q <= 1'b0; idx <= '0;
      id0_q <= '0; id1_q <= '0; v1_q <= 1'b0;
    end else begin
      busy <= busy_d; slot_q <= slot_d; idx <= idx_d;
      id0_q <= id0_d; id1_q <= id1_d; v1_q <= v1_d;
    end
  end

  // R6: inside a row the read address steps by one each cycle
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != '0) |-> (raddr == $past(raddr) + AW'(1)));
endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
  import stdp_pkg::*;
#(
  parameter int N_IN  = 784,
  parameter int N_NEU = 200,
  localparam int AW   = (N_IN * N_NEU > 1) ? $clog2(N_IN * N_NEU) : 1,
  localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int NW   = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  input  logic            start,
  input  logic [NW-1:0]   win0_id,
  input  logic            win0_vld,
  input  logic [NW-1:0]   win1_id,
  input  logic            win1_vld,
  input  logic [N_IN-1:0] in_vec,
  output logic            mem_re,
  output logic [AW-1:0]   mem_raddr,
  input  logic [7:0]      mem_rdata,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [7:0]      mem_wdata,
  output logic            done
);
  stdp_cfg_t cfg;
  logic busy, last, empty_go;
  logic [IW-1:0] idx;
  logic [AW-1:0] raddr;

  stdp_cfg_reg u_cfg (.clk, .rst_n, .we(cfg_we), .wdata(cfg_wdata), .cfg);

  stdp_walk #(.N_IN(N_IN), .N_NEU(N_NEU), .AW(AW), .IW(IW), .NW(NW)) u_walk (
    .clk, .rst_n, .start, .id0(win0_id), .vld0(win0_vld), .id1(win1_id), .vld1(win1_vld),
    .busy, .idx, .raddr, .last, .empty_go);

  // Input vector captured when a pass is accepted
  logic [N_IN-1:0] vec_q, vec_d;
  logic            cap_en;
  assign cap_en = start && !busy;
  always_comb vec_d = cap_en ? in_vec : vec_q;

  // Write-back stage, one cycle behind the read
  logic          rv_q, act_q, last_q, fw_q, done_q;
  logic [AW-1:0] wa_q;
  logic [7:0]    fwv_q, w_cur, w_new;
  logic          fw_d;

  assign w_cur = fw_q ? fwv_q : mem_rdata;
  stdp_weight_alu u_alu (.w_in(w_cur), .active(act_q), .cfg, .w_out(w_new));

  // Same-cycle write and re-read of one address: memory returns stale data
  assign fw_d = busy && rv_q && (raddr == wa_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0; rv_q <= 1'b0; act_q <= 1'b0; last_q <= 1'b0;
      wa_q <= '0; fw_q <= 1'b0; fwv_q <= '0; done_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      rv_q   <= busy;
      act_q  <= vec_q[idx];
      last_q <= last;
      wa_q   <= raddr;
      fw_q   <= fw_d;
      fwv_q  <= w_new;
      done_q <= (rv_q && last_q) || empty_go;
    end
  end

  assign mem_re    = busy;
  assign mem_raddr = raddr;
  assign mem_we    = rv_q;
  assign mem_waddr = wa_q;
  assign mem_wdata = w_new;
  assign done      = done_q;

  // R3/R4: every written weight lies inside the configured limits
  a_r4_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cfg.floor <= cfg.ceil) |-> (mem_wdata >= cfg.floor && mem_wdata <= cfg.ceil));
  // R6: write lands on the address read one cycle earlier
  a_r6_write_tracks_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re) && mem_waddr == $past(mem_raddr)));
  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: no write is still pending when done appears
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);
endmodule

// File: tb/tb_stdp_updater.sv
`timescale 1ns/1ps
module tb_stdp_updater;
  localparam int NI = 16, NN = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;

  // main instance
  logic cfg_we = 0, start = 0, v0 = 0, v1 = 0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0] id0 = '0, id1 = '0;
  logic [NI-1:0] vec = '0;
  logic re, we, done;
  logic [6:0] ra, wa;
  logic [7:0] rd, wd;
  logic [7:0] mem [0:NI*NN-1];
  logic [7:0] exp_m [0:NI*NN-1];

  stdp_updater #(.N_IN(NI), .N_NEU(NN)) dut (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .start, .win0_id(id0), .win0_vld(v0),
    .win1_id(id1), .win1_vld(v1), .in_vec(vec), .mem_re(re), .mem_raddr(ra),
    .mem_rdata(rd), .mem_we(we), .mem_waddr(wa), .mem_wdata(wd), .done);

  always @(posedge clk) begin
    if (re) rd <= mem[ra];
    if (we) mem[wa] <= wd;
  end

  // single-input instance for the write/re-read collision
  logic f_start = 0, f_v = 0, f_vec = 0;
  logic [1:0] f_id = 2'd1;
  logic f_re, f_we, f_done;
  logic [1:0] f_ra, f_wa;
  logic [7:0] f_rd, f_wd;
  logic [7:0] fmem [0:3];

  stdp_updater #(.N_IN(1), .N_NEU(4)) dut_fw (
    .clk, .rst_n, .cfg_we(1'b0), .cfg_wdata(32'd0), .start(f_start), .win0_id(f_id),
    .win0_vld(f_v), .win1_id(f_id), .win1_vld(f_v), .in_vec(f_vec), .mem_re(f_re),
    .mem_raddr(f_ra), .mem_rdata(f_rd), .mem_we(f_we), .mem_waddr(f_wa),
    .mem_wdata(f_wd), .done(f_done));

  always @(posedge clk) begin
    if (f_re) f_rd <= fmem[f_ra];
    if (f_we) fmem[f_wa] <= f_wd;
  end

  // port monitor
  int n_re = 0, n_we = 0, n_done = 0, n_log = 0;
  int rlog [0:63];
  always @(negedge clk) begin
    if (re) begin if (n_log < 64) rlog[n_log] = int'(ra); n_log++; n_re++; end
    if (we) n_we++;
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v); end
  endtask

  function automatic int upd(int w, bit a, int up, int dn, int fl, int cl);
    int r = a ? w + up : w - dn;
    if (r < fl) r = fl;
    if (r > cl) r = cl;
    return r;
  endfunction

  task automatic fill();
    for (int a = 0; a < NI*NN; a++) begin mem[a] = 8'((a*37 + 11) & 255); exp_m[a] = mem[a]; end
  endtask

  task automatic model_row(input int row, input int up, input int dn, input int fl, input int cl);
    for (int i = 0; i < NI; i++)
      exp_m[row*NI+i] = 8'(upd(int'(exp_m[row*NI+i]), vec[i], up, dn, fl, cl));
  endtask

  task automatic clear_mon();
    n_re = 0; n_we = 0; n_done = 0; n_log = 0;
  endtask

  task automatic go_wait();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 200 && n_done == 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_mem(input string req);
    for (int a = 0; a < NI*NN; a++) chk(mem[a] == exp_m[a], req, int'(mem[a]), int'(exp_m[a]));
  endtask

  task automatic t_reset();
    chk(done == 0, "R1 done", int'(done), 0);
    chk(re == 0, "R1 mem_re", int'(re), 0);
    chk(we == 0, "R1 mem_we", int'(we), 0);
  endtask

  // R1 defaults, R2 row selection, R3/R4 saturation, R6 order, R7 done count
  task automatic t_default();
    fill();
    mem[2*NI+0] = 8'd250; exp_m[2*NI+0] = 8'd250;
    mem[2*NI+1] = 8'd1;   exp_m[2*NI+1] = 8'd1;
    mem[5*NI+3] = 8'd255; exp_m[5*NI+3] = 8'd255;
    vec = 16'b0000_0000_0000_1001;  // idx0 active, idx1 silent, idx3 active
    id0 = 3'd2; v0 = 1; id1 = 3'd5; v1 = 1;
    model_row(2, 15, 2, 0, 255); model_row(5, 15, 2, 0, 255);
    clear_mon(); go_wait();
    chk(mem[2*NI+0] == 8'd255, "R3 ceiling clamp", int'(mem[2*NI+0]), 255);
    chk(mem[2*NI+1] == 8'd0, "R4 floor clamp", int'(mem[2*NI+1]), 0);
    cmp_mem("R2 R3 R4 default rows");
    chk(n_re == 2*NI, "R6 read count", n_re, 2*NI);
    chk(n_we == 2*NI, "R6 write count", n_we, 2*NI);
    chk(n_done == 1, "R7 done once", n_done, 1);
    for (int k = 0; k < 2*NI; k++) begin
      int e = (k < NI) ? 2*NI + k : 5*NI + (k - NI);
      chk(rlog[k] == e, "R6 address order", rlog[k], e);
    end
  endtask

  // R5 config layout; R2 slot 0 invalid
  task automatic t_cfg();
    @(negedge clk); cfg_we = 1; cfg_wdata = {8'd200, 8'd20, 8'd30, 8'd40};
    @(negedge clk); cfg_we = 0;
    fill();
    mem[7*NI+0] = 8'd190; exp_m[7*NI+0] = 8'd190;
    mem[7*NI+1] = 8'd35;  exp_m[7*NI+1] = 8'd35;
    vec = 16'b1010_0110_0011_0101;
    id0 = 3'd1; v0 = 0; id1 = 3'd7; v1 = 1;
    model_row(7, 40, 30, 20, 200);
    clear_mon(); go_wait();
    chk(mem[7*NI+0] == 8'd200, "R5 ceiling field", int'(mem[7*NI+0]), 200);
    chk(mem[7*NI+1] == 8'd20, "R5 floor field", int'(mem[7*NI+1]), 20);
    cmp_mem("R5 R2 configured row");
    chk(n_we == NI, "R2 only valid slot", n_we, NI);
  endtask

  // R7 empty list
  task automatic t_empty();
    fill(); v0 = 0; v1 = 0; clear_mon();
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    chk(done == 1, "R7 empty done", int'(done), 1);
    @(posedge clk); #1;
    chk(done == 0, "R7 empty done width", int'(done), 0);
    @(negedge clk);
    chk(n_we == 0, "R7 empty no writes", n_we, 0);
    cmp_mem("R2 empty unchanged");
  endtask

  // R9 start during a pass
  task automatic t_busy_start();
    fill(); vec = 16'h00F0;
    id0 = 3'd3; v0 = 1; v1 = 0;
    model_row(3, 40, 30, 20, 200);
    clear_mon();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    id0 = 3'd6; v0 = 1; id1 = 3'd4; v1 = 1; vec = 16'hFFFF; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 200 && n_done == 0; k++) @(negedge clk);
    @(negedge clk);
    chk(n_we == NI, "R9 ignored start writes", n_we, NI);
    cmp_mem("R9 ignored start rows");
  endtask

  // R8 collision forwarding
  task automatic t_fwd(input bit act, input int exp_v);
    fmem[1] = 8'd100; f_vec = act; f_v = 1;
    @(negedge clk); f_start = 1;
    @(negedge clk); f_start = 0;
    repeat (8) @(negedge clk);
    chk(fmem[1] == 8'(exp_v), "R8 double update", int'(fmem[1]), exp_v);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++) fmem[a] = 8'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default();
    t_cfg();
    t_empty();
    t_busy_start();
    t_fwd(1'b1, 130);
    t_fwd(1'b0, 96);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule